// File: doc/BRIEF.md
# Software-generated interrupt dispatcher

This block is the write side of the software interrupt register in an interrupt distributor serving a cluster of up to eight processors. A processor writes one 32-bit word, and the block receives it together with the ID of the CPU that wrote it. From that word the block takes an interrupt number (one of 16), a filter mode and an explicit list of targets. The mode and the writer's ID together give the set of CPUs that receive the interrupt.

For every target CPU and every interrupt number the block keeps two pieces of state: a pending flag and a mask of the CPUs that have raised that interrupt. A write sets the pending flag of every selected target and ORs the writer's bit into that target's source mask. An acknowledge port names one (target, interrupt, source) triple and clears that single source bit. Once a mask is empty, its pending flag drops.

All of this state is brought out as flat vectors for the downstream prioritiser to read. The register itself reads back as zero.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, every pending flag and every source bit is zero.
- R2: Fields of the written word:
  - bits [3:0] give the interrupt number;
  - bits [23:16] give the target list, where bit 16+c selects CPU c;
  - bits [25:24] give the mode;
  - all other bits have no effect.
- R3: Mode 0 selects exactly the listed CPUs. List bits for CPUs at or above NCPU are dropped.
- R4: Mode 1 selects every implemented CPU except the writer. The list field is ignored in this mode.
- R5: Mode 2 selects only the writer. The list field is ignored in this mode.
- R6: A mode 3 write changes no state.
- R7: For each selected target, the write sets pending[t*16+i]. It also sets source[(t*16+i)*NCPU+w], where i is the interrupt number and w is the writer's ID. Both bits are visible after the first rising clock edge at which wr_valid is sampled high.
- R8: An acknowledge (ack_cpu, ack_id, ack_src) clears only that one source bit at the next edge. The pending flag of that entry clears when its source mask becomes zero.
- R9: If a write and an acknowledge hit the same entry in the same cycle, the write's set takes priority. The entry stays pending and the writer's bit ends set.
- R10: rd_data is always zero.
- R11: A write whose writer ID is at or above NCPU changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Written word |
| wr_cpu | input | 3 | ID of the writing CPU |
| rd_data | output | 32 | Read value of the register, always zero |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | 3 | Target CPU being acknowledged |
| ack_id | input | 4 | Interrupt number being acknowledged |
| ack_src | input | 3 | Source bit to clear |
| pending | output | NCPU*16 | Pending flags, index t*16+i |
| source | output | NCPU*16*NCPU | Source masks, index (t*16+i)*NCPU+s |

## Verification
The assertions check the following properties on every cycle:
- each pending flag agrees with whether its source mask is non-empty;
- a write leaves the writer's bit set at each target it hits;
- an acknowledge removes its bit, unless a write to the same bit arrives in the same cycle;
- a reserved-mode write leaves all state stable;
- the all-but-self and self-only modes produce the right target shapes.

Only the bench scenarios can show the following:
- that the fields are taken from the right bit positions;
- that list bits above NCPU are dropped;
- that a mask with several sources keeps its entry pending until the last acknowledge;
- that a write from an unimplemented CPU ID is ignored.

Those scenarios compare every output bit against a behavioural model on every clock.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int CPU_W   = 3;
  localparam int ID_W    = 4;
  localparam int NUM_ID  = 1 << ID_W;
  localparam int MAX_CPU = 1 << CPU_W;
  localparam int LIST_LO = 16;
  localparam int MODE_LO = 24;

  typedef enum logic [1:0] {
    MODE_LIST   = 2'd0,
    MODE_OTHERS = 2'd1,
    MODE_SELF   = 2'd2,
    MODE_RSVD   = 2'd3
  } sgi_mode_e;
endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
  import sgi_pkg::*;
#(
  parameter int NCPU = 8
) (
  input  logic             wr_valid,
  input  logic [31:0]      wr_data,
  input  logic [CPU_W-1:0] wr_cpu,
  output logic             wr_go,
  output logic [ID_W-1:0]  wr_id,
  output sgi_mode_e        wr_mode,
  output logic [NCPU-1:0]  tgt
);
  logic [MAX_CPU-1:0] list;
  logic               cpu_ok;

  always_comb begin
    wr_id   = wr_data[ID_W-1:0];
    list    = wr_data[LIST_LO +: MAX_CPU];
    wr_mode = sgi_mode_e'(wr_data[MODE_LO +: 2]);
    cpu_ok  = ({1'b0, wr_cpu} < (CPU_W+1)'(NCPU));
    wr_go   = wr_valid && cpu_ok && (wr_mode != MODE_RSVD);
    for (int c = 0; c < NCPU; c++) begin
      case (wr_mode)
        MODE_LIST:   tgt[c] = list[c];
        MODE_OTHERS: tgt[c] = (wr_cpu != CPU_W'(c));
        MODE_SELF:   tgt[c] = (wr_cpu == CPU_W'(c));
        default:     tgt[c] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sgi_target_bank.sv
module sgi_target_bank
  import sgi_pkg::*;
#(
  parameter int NCPU = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_hit,
  input  logic [ID_W-1:0]        wr_id,
  input  logic [CPU_W-1:0]       wr_cpu,
  input  logic                   ack_hit,
  input  logic [ID_W-1:0]        ack_id,
  input  logic [CPU_W-1:0]       ack_src,
  output logic [NUM_ID-1:0]      pend_o,
  output logic [NUM_ID*NCPU-1:0] src_o
);
  logic [NUM_ID-1:0] pend_q, pend_n;
  logic [NCPU-1:0]   src_q [NUM_ID];
  logic [NCPU-1:0]   src_n [NUM_ID];
  logic              upd_en;

  assign upd_en = wr_hit || ack_hit;

  always_comb begin
    pend_n = pend_q;
    for (int i = 0; i < NUM_ID; i++) src_n[i] = src_q[i];
    if (ack_hit) begin
      for (int s = 0; s < NCPU; s++)
        if (ack_src == CPU_W'(s)) src_n[ack_id][s] = 1'b0;
      if (src_n[ack_id] == '0) pend_n[ack_id] = 1'b0;
    end
    if (wr_hit) begin
      for (int s = 0; s < NCPU; s++)
        if (wr_cpu == CPU_W'(s)) src_n[wr_id][s] = 1'b1;
      pend_n[wr_id] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int i = 0; i < NUM_ID; i++) src_q[i] <= '0;
    end else if (upd_en) begin
      pend_q <= pend_n;
      for (int i = 0; i < NUM_ID; i++) src_q[i] <= src_n[i];
    end
  end

  assign pend_o = pend_q;
  for (genvar gi = 0; gi < NUM_ID; gi++) begin : g_flat
    assign src_o[gi*NCPU +: NCPU] = src_q[gi];

    assert_pend_tracks_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[gi] == (src_q[gi] != '0));
  end

  assert_write_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> pend_q[$past(wr_id)] && src_q[$past(wr_id)][$past(wr_cpu)]);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !(wr_hit && wr_id == ack_id && wr_cpu == ack_src) &&
     ({1'b0, ack_src} < (CPU_W+1)'(NCPU)))
    |=> !src_q[$past(ack_id)][$past(ack_src)]);

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && ack_hit && wr_id == ack_id) |=> pend_q[$past(wr_id)]);
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NCPU = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_valid,
  input  logic [31:0]                 wr_data,
  input  logic [2:0]                  wr_cpu,
  output logic [31:0]                 rd_data,
  input  logic                        ack_valid,
  input  logic [2:0]                  ack_cpu,
  input  logic [3:0]                  ack_id,
  input  logic [2:0]                  ack_src,
  output logic [NCPU*16-1:0]          pending,
  output logic [NCPU*16*NCPU-1:0]     source
);
  localparam int BANK_W = NUM_ID * NCPU;

  logic            wr_go;
  logic [ID_W-1:0] wr_id;
  sgi_mode_e       wr_mode;
  logic [NCPU-1:0] tgt;
  logic            unused_bits;

  assign unused_bits = ^{wr_data[31:26], wr_data[15:4]};
  assign rd_data     = '0;

  sgi_decode #(.NCPU(NCPU)) u_decode (
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .wr_cpu   (wr_cpu),
    .wr_go    (wr_go),
    .wr_id    (wr_id),
    .wr_mode  (wr_mode),
    .tgt      (tgt)
  );

  for (genvar gt = 0; gt < NCPU; gt++) begin : g_tgt
    logic ack_hit;
    assign ack_hit = ack_valid && (ack_cpu == CPU_W'(gt));

    sgi_target_bank #(.NCPU(NCPU)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_go && tgt[gt]),
      .wr_id   (wr_id),
      .wr_cpu  (wr_cpu),
      .ack_hit (ack_hit),
      .ack_id  (ack_id),
      .ack_src (ack_src),
      .pend_o  (pending[gt*NUM_ID +: NUM_ID]),
      .src_o   (source[gt*BANK_W +: BANK_W])
    );
  end

  assert_rsvd_nochange_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_data[25:24] == 2'd3 && !ack_valid)
    |=> ($stable(pending) && $stable(source)));

  assert_not_self_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wr_mode == MODE_OTHERS) |-> !tgt[wr_cpu]);

  assert_self_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wr_mode == MODE_SELF) |-> ($countones(tgt) == 1 && tgt[wr_cpu]));
endmodule

// File: tb/sgi_dispatch_tb.sv
`timescale 1ns/1ps
module sgi_dispatch_tb;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic [2:0] wr_cpu = '0;
  logic ack_valid = 1'b0;
  logic [2:0] ack_cpu = '0;
  logic [3:0] ack_id = '0;
  logic [2:0] ack_src = '0;
  logic [31:0] rd_data;
  logic [N*16-1:0] pending;
  logic [N*16*N-1:0] source;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic mp [N][16];
  logic ms [N][16][N];

  always #2 clk = ~clk;

  sgi_dispatch #(.NCPU(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_cpu(wr_cpu), .rd_data(rd_data), .ack_valid(ack_valid),
    .ack_cpu(ack_cpu), .ack_id(ack_id), .ack_src(ack_src),
    .pending(pending), .source(source)
  );

  // Behavioural reference: acknowledge first, then write (write wins)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < N; t++)
        for (int i = 0; i < 16; i++) begin
          mp[t][i] = 0;
          for (int s = 0; s < N; s++) ms[t][i][s] = 0;
        end
    end else begin
      if (ack_valid && ack_cpu < N && ack_src < N) begin
        int any;
        ms[ack_cpu][ack_id][ack_src] = 0;
        any = 0;
        for (int s = 0; s < N; s++) if (ms[ack_cpu][ack_id][s]) any = 1;
        if (any == 0) mp[ack_cpu][ack_id] = 0;
      end
      if (wr_valid && wr_cpu < N && wr_data[25:24] != 2'd3) begin
        for (int t = 0; t < N; t++) begin
          bit sel;
          case (wr_data[25:24])
            2'd0:    sel = wr_data[16+t];
            2'd1:    sel = (t != int'(wr_cpu));
            default: sel = (t == int'(wr_cpu));
          endcase
          if (sel) begin
            mp[t][wr_data[3:0]] = 1;
            ms[t][wr_data[3:0]][wr_cpu] = 1;
          end
        end
      end
    end
  end

  // Every-cycle comparison against the model (R7, R8 state)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int bad;
      bad = 0;
      for (int t = 0; t < N; t++)
        for (int i = 0; i < 16; i++) begin
          if (pending[t*16+i] !== mp[t][i]) bad++;
          for (int s = 0; s < N; s++)
            if (source[(t*16+i)*N+s] !== ms[t][i][s]) bad++;
        end
      checks++;
      if (bad != 0) begin
        errors++;
        $display("FAIL R7 model compare at %0t: actual %0d mismatching bits, expected 0", $time, bad);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic pb(int t, int i);
    return pending[t*16+i];
  endfunction

  function automatic logic sb(int t, int i, int s);
    return source[(t*16+i)*N+s];
  endfunction

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [31:0] d, input logic [2:0] c);
    wr_valid = 1; wr_data = d; wr_cpu = c;
    cyc();
    wr_valid = 0; wr_data = '0;
  endtask

  task automatic ack(input logic [2:0] t, input logic [3:0] i, input logic [2:0] s);
    ack_valid = 1; ack_cpu = t; ack_id = i; ack_src = s;
    cyc();
    ack_valid = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*16-1:0] snap_p;
    logic [N*16*N-1:0] snap_s;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    cyc();
    // R1 reset state, R10 read value
    chk("R1 pending zero", |pending, 1'b0);
    chk("R1 source zero", |source, 1'b0);
    chk("R10 rd_data zero", |rd_data, 1'b0);

    // R2/R3: mode 0, id 5, list CPUs 0,2,6,7 from CPU 1, junk in unused bits
    wr(32'hFCC5_FFF5, 3'd1);
    cyc();
    chk("R3 t0 pending", pb(0,5), 1'b1);
    chk("R3 t2 pending", pb(2,5), 1'b1);
    chk("R3 t1 not listed", pb(1,5), 1'b0);
    chk("R2 id bits only", pb(0,15), 1'b0);
    chk("R7 source writer bit", sb(0,5,1), 1'b1);
    chk("R7 source other bit", sb(0,5,0), 1'b0);

    // R4: mode 1 from CPU 3, id 9, list field only CPU 3
    wr(32'h0108_0009, 3'd3);
    cyc();
    chk("R4 writer excluded", pb(3,9), 1'b0);
    chk("R4 t5 included", pb(5,9), 1'b1);
    chk("R4 t0 included", pb(0,9), 1'b1);

    // R5: mode 2 from CPU 4, id 2, list all ones
    wr(32'h02FF_0002, 3'd4);
    cyc();
    chk("R5 self", pb(4,2), 1'b1);
    chk("R5 other", pb(0,2), 1'b0);
    chk("R10 rd_data zero after writes", |rd_data, 1'b0);

    // R6: reserved mode
    snap_p = pending; snap_s = source;
    wr(32'h03FF_000C, 3'd0);
    cyc();
    chk("R6 pending unchanged", pending == snap_p, 1'b1);
    chk("R6 source unchanged", source == snap_s, 1'b1);

    // R11: writer ID beyond NCPU
    wr(32'h0200_0007, 3'd7);
    wr(32'h0001_0007, 3'd6);
    cyc();
    chk("R11 bad writer ignored", pending == snap_p, 1'b1);

    // R8: single source acknowledge
    ack(3'd0, 4'd5, 3'd1);
    cyc();
    chk("R8 cleared pending", pb(0,5), 1'b0);
    chk("R8 cleared source", sb(0,5,1), 1'b0);
    chk("R8 other target kept", pb(2,5), 1'b1);

    // R8: two sources on t4 id 2
    wr(32'h0010_0002, 3'd0);
    ack(3'd4, 4'd2, 3'd4);
    cyc();
    chk("R8 still pending with one source", pb(4,2), 1'b1);
    chk("R8 remaining source", sb(4,2,0), 1'b1);
    ack(3'd4, 4'd2, 3'd0);
    cyc();
    chk("R8 last source cleared", pb(4,2), 1'b0);

    // R9: write and acknowledge on t2 id 5 src 1 together
    wr_valid = 1; wr_data = 32'h0004_0005; wr_cpu = 3'd1;
    ack_valid = 1; ack_cpu = 3'd2; ack_id = 4'd5; ack_src = 3'd1;
    cyc();
    wr_valid = 0; ack_valid = 0;
    cyc();
    chk("R9 pending kept", pb(2,5), 1'b1);
    chk("R9 source kept", sb(2,5,1), 1'b1);

    repeat (2) cyc();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule